// File: doc/BRIEF.md
# Single-Byte Increment Execution Unit

This unit carries out the one-byte increment instruction of a small 8-bit processor core. It keeps the seven general registers (accumulator plus B, C, D, E, H, L) and the flag byte. It takes an opcode when idle and adds one to the chosen register. When the opcode names the memory target, it adds one to the byte at the address formed from H (high) and L (low). The memory form runs as a fixed sequence of three machine cycles on a simple synchronous bus: fetch, read, then write back. The unit reports how many T-states (clock cycles) each instruction used.

Sign, zero, auxiliary-carry and parity follow the new 8-bit value. Carry and the unused flag bits are never touched by the increment. The rest of the datapath preloads registers and flags through a small write port while the unit is idle. Any opcode outside the increment pattern is rejected with a one-cycle pulse.

Top module: `incr_exec_unit`

## Requirements
- R1: An opcode is accepted only if bits 7:6 are 00 and bits 2:0 are 100. Bits 5:3 pick the target: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 110 memory, 111 A. Register slot i is byte i of `regs_o` (bits 8i+7:8i), and byte 6 always reads 00.
- R2: A register-target increment replaces that register with its value plus one modulo 256. Every other register is unchanged.
- R3: On completion, flag bit 7 (sign) equals result bit 7 and bit 6 (zero) is set when the result is 00. Bit 4 (auxiliary carry) is set when the old low nibble was F. Bit 2 (parity) is set when the result has an even number of ones.
- R4: The increment never changes flag bits 0 (carry), 1, 3 and 5.
- R5: The memory form drives `mem_addr_o` = {H, L}. It holds `mem_rd_o` for 3 cycles, samples `mem_rdata_i` in the last of them, then holds `mem_wr_o` for 3 cycles with `mem_wdata_o` = read value + 1. The two strobes are never high together, and the address is 0 when neither is high.
- R6: A register form completes 4 cycles after acceptance (acceptance cycle included) and a memory form 10 cycles after. `done_o` pulses for one cycle right after the last T-state, with `tstates_o` = 4 or 10 respectively from then on.
- R7: An illegal opcode presented while idle gives a one-cycle `illegal_o` pulse in the next cycle. It leaves busy low and changes no register, flag or bus output.
- R8: `busy_o` is high from the cycle after acceptance through the last T-state. `op_valid_i` and the load port have no effect while busy.
- R9: When idle with `op_valid_i` low, `ld_en_i` writes `ld_data_i` into slot `ld_slot_i` (0-5, 7 registers; 6 the flag byte), visible the next cycle. If `op_valid_i` is high in the same cycle, the load is dropped.
- R10: After reset all registers, flags and `tstates_o` are 0, and busy, done, illegal and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode offered |
| op_byte_i | input | 8 | Opcode byte |
| ld_en_i | input | 1 | Preload strobe |
| ld_slot_i | input | 3 | Preload slot (6 = flags) |
| ld_data_i | input | 8 | Preload value |
| mem_rdata_i | input | 8 | Memory read data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Rejected-opcode pulse |
| tstates_o | output | 4 | T-states of last instruction |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| flags_o | output | 8 | Flag byte |
| regs_o | output | 64 | Register slots, byte per slot |

## Verification
The hardest case to reach is a carry that is already set when an increment wraps FF to 00. Reset always clears carry and no increment ever sets it, so the bench preloads the flag byte with carry and the spare bits set through the load port. It then steps registers and a memory byte across the wrap. A second hard corner is input arriving during the ten-cycle memory sequence. The bench holds a different opcode and a load request high while busy and confirms neither takes effect. A behavioural model follows every cycle, including back-to-back issue with `op_valid_i` held high.

// File: rtl/incr_pkg.sv
package incr_pkg;
    localparam int DW     = 8;
    localparam int NSLOT  = 8;
    localparam int SLOT_M = 6;
    localparam int F_S    = 7;
    localparam int F_Z    = 6;
    localparam int F_AC   = 4;
    localparam int F_P    = 2;
    localparam int F_CY   = 0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_MRD   = 2'd2,
        PH_MWR   = 2'd3
    } phase_e;
endpackage

// File: rtl/incr_decode.sv
module incr_decode (
    input  logic [7:0] opcode_i,
    output logic       legal_o,
    output logic [2:0] slot_o
);
    // pattern 00 sss 100, sss picks the target slot
    assign legal_o = (opcode_i[7:6] == 2'b00) && (opcode_i[2:0] == 3'b100);
    assign slot_o  = opcode_i[5:3];
endmodule

// File: rtl/incr_alu.sv
module incr_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] old_i,
    output logic [W-1:0] sum_o,
    output logic         sign_o,
    output logic         zero_o,
    output logic         half_o,
    output logic         even_o
);
    assign sum_o  = old_i + 1'b1;
    assign sign_o = sum_o[W-1];
    assign zero_o = (sum_o == '0);
    assign half_o = &old_i[3:0];
    assign even_o = ~^sum_o;

    // R3: a carry out of the low nibble must leave a zero low nibble
    always_comb begin
        if (!$isunknown(old_i)) begin
            a_r3_half_wrap: assert (half_o == (sum_o[3:0] == 4'h0));
        end
    end
endmodule

// File: rtl/incr_exec_unit.sv
module incr_exec_unit
    import incr_pkg::*;
#(
    parameter int T_FETCH = 4,
    parameter int T_MEM   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid_i,
    input  logic [7:0]           op_byte_i,
    input  logic                 ld_en_i,
    input  logic [2:0]           ld_slot_i,
    input  logic [7:0]           ld_data_i,
    input  logic [7:0]           mem_rdata_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 illegal_o,
    output logic [3:0]           tstates_o,
    output logic [15:0]          mem_addr_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic [7:0]           mem_wdata_o,
    output logic [7:0]           flags_o,
    output logic [63:0]          regs_o
);
    localparam int TMAX = (T_FETCH > T_MEM) ? T_FETCH : T_MEM;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int TTOT = T_FETCH + 2 * T_MEM;
    localparam int CW   = $clog2(TTOT + 1);
    localparam int AW   = 2 * DW;

    typedef struct packed {
        phase_e                    ph;
        logic [TW-1:0]             t;
        logic [2:0]                slot;
        logic [DW-1:0]             data;
        logic [3:0]                pend;
        logic [DW-1:0]             flags;
        logic [NSLOT-1:0][DW-1:0]  regs;
        logic [CW-1:0]             run;
        logic [CW-1:0]             tsum;
        logic                      done;
        logic                      ill;
    } state_t;

    state_t q, n;

    logic          dec_legal;
    logic [2:0]    dec_slot;
    logic [DW-1:0] alu_in, alu_sum;
    logic          alu_s, alu_z, alu_ac, alu_p;

    incr_decode u_dec (
        .opcode_i (op_byte_i),
        .legal_o  (dec_legal),
        .slot_o   (dec_slot)
    );

    assign alu_in = (q.ph == PH_MRD) ? mem_rdata_i : q.regs[q.slot];

    incr_alu #(.W(DW)) u_alu (
        .old_i  (alu_in),
        .sum_o  (alu_sum),
        .sign_o (alu_s),
        .zero_o (alu_z),
        .half_o (alu_ac),
        .even_o (alu_p)
    );

    function automatic logic [DW-1:0] put_flags(input logic [DW-1:0] f, input logic [3:0] v);
        logic [DW-1:0] r;
        r       = f;
        r[F_S]  = v[3];
        r[F_Z]  = v[2];
        r[F_AC] = v[1];
        r[F_P]  = v[0];
        return r;
    endfunction

    always_comb begin
        n      = q;
        n.done = 1'b0;
        n.ill  = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (op_valid_i) begin
                    if (dec_legal) begin
                        n.ph   = PH_FETCH;
                        n.t    = TW'(2);
                        n.slot = dec_slot;
                        n.run  = CW'(1);
                    end else begin
                        n.ill = 1'b1;
                    end
                end else if (ld_en_i) begin
                    if (ld_slot_i == 3'(SLOT_M)) n.flags = ld_data_i;
                    else                          n.regs[ld_slot_i] = ld_data_i;
                end
            end
            PH_FETCH: begin
                n.run = q.run + 1'b1;
                if (q.t == TW'(T_FETCH)) begin
                    if (q.slot == 3'(SLOT_M)) begin
                        n.ph = PH_MRD;
                        n.t  = TW'(1);
                    end else begin
                        n.regs[q.slot] = alu_sum;
                        n.flags        = put_flags(q.flags, {alu_s, alu_z, alu_ac, alu_p});
                        n.ph           = PH_IDLE;
                        n.done         = 1'b1;
                        n.tsum         = q.run + 1'b1;
                    end
                end else begin
                    n.t = q.t + 1'b1;
                end
            end
            PH_MRD: begin
                n.run = q.run + 1'b1;
                if (q.t == TW'(T_MEM)) begin
                    n.data = alu_sum;
                    n.pend = {alu_s, alu_z, alu_ac, alu_p};
                    n.ph   = PH_MWR;
                    n.t    = TW'(1);
                end else begin
                    n.t = q.t + 1'b1;
                end
            end
            default: begin
                n.run = q.run + 1'b1;
                if (q.t == TW'(T_MEM)) begin
                    n.flags = put_flags(q.flags, q.pend);
                    n.ph    = PH_IDLE;
                    n.done  = 1'b1;
                    n.tsum  = q.run + 1'b1;
                end else begin
                    n.t = q.t + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy_o      = (q.ph != PH_IDLE);
    assign done_o      = q.done;
    assign illegal_o   = q.ill;
    assign tstates_o   = 4'(q.tsum);
    assign mem_rd_o    = (q.ph == PH_MRD);
    assign mem_wr_o    = (q.ph == PH_MWR);
    assign mem_addr_o  = (mem_rd_o || mem_wr_o) ? AW'({q.regs[4], q.regs[5]}) : '0;
    assign mem_wdata_o = mem_wr_o ? q.data : '0;
    assign flags_o     = q.flags;
    assign regs_o      = q.regs;

    // R4: outside a flag-slot preload, carry and spare bits never move
    a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ph == PH_IDLE && !op_valid_i && ld_en_i && ld_slot_i == 3'(SLOT_M))
        |=> $stable({flags_o[5], flags_o[3], flags_o[1], flags_o[F_CY]}));

    // R5: read and write strobes exclusive
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R5: written byte is the last read byte plus one
    a_r5_wdata_inc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_o) |-> (mem_wdata_o == 8'($past(mem_rdata_i) + 8'd1)));

    // R5: address held through a read cycle
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> $stable(mem_addr_o));

    // R7: rejected opcode pulses and never starts a sequence
    a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !busy_o && !dec_legal) |=> (illegal_o && !busy_o));

    // R6: completion is a single-cycle pulse with a legal length
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r6_done_len: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tstates_o == 4'(T_FETCH) || tstates_o == 4'(TTOT)));
endmodule

// File: tb/incr_exec_unit_tb.sv
module incr_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_slot = 3'd0;
    logic [7:0]  ld_data = 8'h00;
    logic [7:0]  mem_rdata;
    logic        busy, done, illegal, mem_rd, mem_wr;
    logic [3:0]  tstates;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, flags;
    logic [63:0] regs;

    always #5 clk = ~clk;

    incr_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_byte_i(op_byte),
        .ld_en_i(ld_en), .ld_slot_i(ld_slot), .ld_data_i(ld_data),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
        .illegal_o(illegal), .tstates_o(tstates), .mem_addr_o(mem_addr),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
        .flags_o(flags), .regs_o(regs)
    );

    // bus memory: page 40xx, indexed by the low byte
    logic [7:0] mem [0:255];
    always_comb mem_rdata = mem_rd ? mem[mem_addr[7:0]] : 8'h00;
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit ended = 1'b0;

    // reference model
    logic [7:0] m_r [8];
    logic [7:0] m_mem [0:255];
    logic [7:0] m_f, m_wd, m_old;
    int m_ph, m_t, m_ts;
    logic [2:0] m_slot;
    bit m_done, m_ill;

    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] old);
        logic [7:0] r;
        logic [7:0] res;
        int ones;
        res = old + 8'd1;
        ones = 0;
        for (int i = 0; i < 8; i++) if (res[i]) ones++;
        r = f;
        r[7] = (res >= 8'd128);
        r[6] = (res == 8'd0);
        r[4] = ((old % 16) == 15);
        r[2] = ((ones % 2) == 0);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
            m_f = 8'h00; m_ph = 0; m_t = 0; m_ts = 0; m_done = 0; m_ill = 0;
            m_wd = 8'h00; m_old = 8'h00; m_slot = 3'd0;
        end else begin
            m_done = 0; m_ill = 0;
            case (m_ph)
                0: begin
                    if (op_valid) begin
                        if (op_byte[7:6] == 2'b00 && op_byte[2:0] == 3'b100) begin
                            m_ph = 1; m_t = 2; m_slot = op_byte[5:3];
                        end else m_ill = 1;
                    end else if (ld_en) begin
                        if (ld_slot == 3'd6) m_f = ld_data;
                        else m_r[ld_slot] = ld_data;
                    end
                end
                1: begin
                    if (m_t == 4) begin
                        if (m_slot == 3'd6) begin m_ph = 2; m_t = 1; end
                        else begin
                            m_f = next_flags(m_f, m_r[m_slot]);
                            m_r[m_slot] = m_r[m_slot] + 8'd1;
                            m_ph = 0; m_done = 1; m_ts = 4;
                        end
                    end else m_t++;
                end
                2: begin
                    if (m_t == 3) begin
                        m_old = m_mem[m_r[5]];
                        m_wd = m_old + 8'd1;
                        m_ph = 3; m_t = 1;
                    end else m_t++;
                end
                default: begin
                    if (m_t == 3) begin
                        m_mem[m_r[5]] = m_wd;
                        m_f = next_flags(m_f, m_old);
                        m_done = 1; m_ts = 10; m_ph = 0;
                    end else m_t++;
                end
            endcase
        end
    end

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            logic [63:0] er;
            logic        erd, ewr;
            vectors++;
            for (int i = 0; i < 8; i++) er[i*8 +: 8] = (i == 6) ? 8'h00 : m_r[i];
            erd = (m_ph == 2);
            ewr = (m_ph == 3);
            cmp("R2 regs", regs, er);
            cmp("R3 flags", 64'({flags[7:6], flags[4], flags[2]}), 64'({m_f[7:6], m_f[4], m_f[2]}));
            cmp("R4 carry/spare", 64'({flags[5], flags[3], flags[1], flags[0]}),
                64'({m_f[5], m_f[3], m_f[1], m_f[0]}));
            cmp("R8 busy", 64'(busy), 64'(m_ph != 0));
            cmp("R5 rd strobe", 64'(mem_rd), 64'(erd));
            cmp("R5 wr strobe", 64'(mem_wr), 64'(ewr));
            cmp("R5 address", 64'(mem_addr), (erd || ewr) ? 64'({m_r[4], m_r[5]}) : 64'd0);
            cmp("R5 wdata", 64'(mem_wdata), ewr ? 64'(m_wd) : 64'd0);
            cmp("R6 done", 64'(done), 64'(m_done));
            cmp("R6 tstates", 64'(tstates), 64'(m_ts));
            cmp("R7 illegal", 64'(illegal), 64'(m_ill));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        while (m_ph != 0) @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] o);
        op_valid = 1'b1; op_byte = o;
        @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        @(negedge clk);
    endtask

    task automatic load(input logic [2:0] s, input logic [7:0] d);
        ld_en = 1'b1; ld_slot = s; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            m_mem[i] = 8'(i * 7 + 3);
        end
        mem[8'h50] = 8'h05; m_mem[8'h50] = 8'h05;
        mem[8'hFF] = 8'hFF; m_mem[8'hFF] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        vectors++;
        cmp("R10 reset regs", regs, 64'd0);
        cmp("R10 reset flags/ts/strobes", 64'({flags, tstates, busy, done, illegal, mem_rd, mem_wr}), 64'd0);

        // R9 preload, then R2/R3 basic increment of B
        load(3'd0, 8'h05);
        vectors++;
        cmp("R9 load B", 64'(regs[7:0]), 64'h05);
        issue(8'h04);

        // R4: carry and spare bits preset, wrap FF->00 on C
        load(3'd6, 8'h2B);
        load(3'd1, 8'hFF);
        issue(8'h0C);
        vectors++;
        cmp("R4 carry after wrap", 64'(flags[0]), 64'd1);
        cmp("R3 wrap Z/AC/P", 64'({flags[6], flags[4], flags[2], flags[7]}), 64'b1110);

        // R1: every target slot with varied starting values
        load(3'd2, 8'h7F); load(3'd3, 8'h0F); load(3'd4, 8'h40);
        load(3'd5, 8'h50); load(3'd7, 8'hFE);
        for (int s = 0; s < 8; s++) begin
            if (s != 6) issue(8'({2'b00, 3'(s), 3'b100}));
        end

        // R5: memory form at 4050 holding 05, flags preset clear
        load(3'd6, 8'h00);
        load(3'd4, 8'h40); load(3'd5, 8'h50);
        issue(8'h34);
        vectors++;
        cmp("R5 mem 4050", 64'(mem[8'h50]), 64'h06);
        cmp("R3 mem flags S Z AC P", 64'({flags[7], flags[6], flags[4], flags[2]}), 64'b0001);
        cmp("R6 mem tstates", 64'(tstates), 64'd10);

        // R5 + R4: memory wrap with carry set
        load(3'd6, 8'h01);
        load(3'd5, 8'hFF);
        issue(8'h34);
        vectors++;
        cmp("R5 mem 40FF wrap", 64'(mem[8'hFF]), 64'h00);
        cmp("R4 carry kept mem", 64'(flags[0]), 64'd1);

        // R7: illegal opcodes
        issue(8'h00); issue(8'h05); issue(8'h44); issue(8'hC4); issue(8'h3D);

        // R8: opcode and load held during a memory sequence are ignored
        load(3'd5, 8'h10);
        op_valid = 1'b1; op_byte = 8'h34;
        @(negedge clk);
        op_byte = 8'h3C; ld_en = 1'b1; ld_slot = 3'd0; ld_data = 8'hAA;
        repeat (6) @(negedge clk);
        op_valid = 1'b0; ld_en = 1'b0;
        wait_idle();
        @(negedge clk);

        // R9: load dropped when an opcode is offered in the same cycle
        op_valid = 1'b1; op_byte = 8'h0C; ld_en = 1'b1; ld_slot = 3'd1; ld_data = 8'h77;
        @(negedge clk);
        op_valid = 1'b0; ld_en = 1'b0;
        wait_idle();
        @(negedge clk);

        // R6: back-to-back issue with op_valid held high
        op_valid = 1'b1; op_byte = 8'h04;
        repeat (14) @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        @(negedge clk);

        // R3: sweep A through every value
        load(3'd7, 8'h00);
        for (int k = 0; k < 258; k++) issue(8'h3C);

        // R5: bench memory matches model memory
        for (int i = 0; i < 256; i++) begin
            vectors++;
            cmp("R5 memory image", 64'(mem[i]), 64'(m_mem[i]));
        end

        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule